// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits beside the decode stage of a five-stage in-order pipeline. It supplies the two source operands of the instruction being decoded. For each operand it compares the source register address with the destination of the instruction now in execute and with the destination of the instruction now in memory. It then hands the decoder one of three values: the execute-stage ALU result, the value leaving the memory stage (load data included), or the register-file read data.

The memory-stage path is blocked whenever the instruction in execute writes the same register, because that instruction is younger. Register zero always reads as zero, whatever path or file data is present. Results from write-back are not forwarded here. The register file is expected to make a same-cycle write visible to the read. The block has no clock and no state. Both per-operand select flags are driven out so the rest of the pipeline can observe them.

Top module: `decode_bypass`

## Requirements
- R1: `rs_sel_ex` is 1 exactly when `ex_wen` is 1, `rs_addr` equals `ex_dst`, and `rs_addr` is not 0.
- R2: `rs_sel_mem` is 1 exactly when `mem_wen` is 1, `rs_addr` equals `mem_dst`, `rs_addr` is not 0, and it is not the case that `ex_wen` is 1 with `ex_dst` equal to `rs_addr`.
- R3: The rt operand follows R1, R2 and R4 to R7 using `rt_addr` and `rt_rf_data`, independently of the rs operand.
- R4: When an operand's execute select is 1, its data output equals `ex_result`.
- R5: When an operand's memory select is 1, its data output equals `mem_result`.
- R6: When neither select of an operand is 1 and its address is not 0, its data output equals its register-file read data.
- R7: When an operand's address is 0, its data output is 0 and both of its selects are 0, even if the file data, `ex_result` or `mem_result` are nonzero.
- R8: For each operand, at most one of its two select flags is 1.
- R9: All outputs are a function of the present inputs alone; a change on an input is reflected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_addr | input | 5 | First source register address |
| rt_addr | input | 5 | Second source register address |
| rs_rf_data | input | 32 | Register-file read data for the first source |
| rt_rf_data | input | 32 | Register-file read data for the second source |
| ex_dst | input | 5 | Destination address of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute will write its destination |
| ex_result | input | 32 | ALU result of the instruction in execute |
| mem_dst | input | 5 | Destination address of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory will write its destination |
| mem_result | input | 32 | Value leaving the memory stage, load data included |
| rs_data | output | 32 | Selected first operand |
| rt_data | output | 32 | Selected second operand |
| rs_sel_ex | output | 1 | First operand taken from execute |
| rs_sel_mem | output | 1 | First operand taken from memory |
| rt_sel_ex | output | 1 | Second operand taken from execute |
| rt_sel_mem | output | 1 | Second operand taken from memory |

## Verification
Every result is due zero cycles after its stimulus, since nothing in the path is registered. The bench applies a new input vector just after each rising edge of its own clock. It compares all six outputs with its behavioural model at the following falling edge, so every value has settled before it is sampled. Directed vectors cover each match, suppression and register-zero case. Pseudo-random vectors drawn from a narrow address range then cause frequent collisions between the two stages and both operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Origin of an operand chosen by the bypass selector
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_MEM = 2'd1,
    SRC_EX  = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              wen,
  output logic              hit
);

  logic addr_eq;
  logic addr_nz;

  always_comb begin
    addr_eq = (src_addr == dst_addr);
    addr_nz = |src_addr;
    hit     = wen & addr_eq & addr_nz;
  end

endmodule

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
  import fwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [ADDR_W-1:0] mem_dst,
  input  logic              mem_wen,
  output logic              sel_ex,
  output logic              sel_mem,
  output src_e              src
);

  logic ex_hit;
  logic mem_hit;

  fwd_hit #(.ADDR_W(ADDR_W)) u_ex_hit (
    .src_addr (src_addr),
    .dst_addr (ex_dst),
    .wen      (ex_wen),
    .hit      (ex_hit)
  );

  fwd_hit #(.ADDR_W(ADDR_W)) u_mem_hit (
    .src_addr (src_addr),
    .dst_addr (mem_dst),
    .wen      (mem_wen),
    .hit      (mem_hit)
  );

  // The younger writer in execute shadows the older one in memory.
  always_comb begin
    sel_ex  = ex_hit;
    sel_mem = mem_hit & ~ex_hit;
    if (src_addr == '0) begin
      src = SRC_ZERO;
    end else if (sel_ex) begin
      src = SRC_EX;
    end else if (sel_mem) begin
      src = SRC_MEM;
    end else begin
      src = SRC_RF;
    end
  end

endmodule

// File: rtl/fwd_data_mux.sv
module fwd_data_mux
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  src_e              src,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [DATA_W-1:0] mem_result,
  output logic [DATA_W-1:0] operand
);

  always_comb begin
    unique case (src)
      SRC_EX:   operand = ex_result;
      SRC_MEM:  operand = mem_result;
      SRC_RF:   operand = rf_data;
      default:  operand = '0;
    endcase
  end

endmodule

// File: rtl/decode_bypass.sv
module decode_bypass
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [DATA_W-1:0] rs_rf_data,
  input  logic [DATA_W-1:0] rt_rf_data,
  input  logic [ADDR_W-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic [DATA_W-1:0] ex_result,
  input  logic [ADDR_W-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [DATA_W-1:0] mem_result,
  output logic [DATA_W-1:0] rs_data,
  output logic [DATA_W-1:0] rt_data,
  output logic              rs_sel_ex,
  output logic              rs_sel_mem,
  output logic              rt_sel_ex,
  output logic              rt_sel_mem
);

  // Index 0 is the rs operand, index 1 the rt operand.
  logic [ADDR_W-1:0] addr_v    [NUM_SRC];
  logic [DATA_W-1:0] rf_v      [NUM_SRC];
  logic [DATA_W-1:0] data_v    [NUM_SRC];
  logic              sel_ex_v  [NUM_SRC];
  logic              sel_mem_v [NUM_SRC];
  src_e              src_v     [NUM_SRC];

  always_comb begin
    addr_v[0] = rs_addr;
    addr_v[1] = rt_addr;
    rf_v[0]   = rs_rf_data;
    rf_v[1]   = rt_rf_data;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_sel_unit #(.ADDR_W(ADDR_W)) u_sel (
      .src_addr (addr_v[g]),
      .ex_dst   (ex_dst),
      .ex_wen   (ex_wen),
      .mem_dst  (mem_dst),
      .mem_wen  (mem_wen),
      .sel_ex   (sel_ex_v[g]),
      .sel_mem  (sel_mem_v[g]),
      .src      (src_v[g])
    );

    fwd_data_mux #(.DATA_W(DATA_W)) u_mux (
      .src        (src_v[g]),
      .rf_data    (rf_v[g]),
      .ex_result  (ex_result),
      .mem_result (mem_result),
      .operand    (data_v[g])
    );
  end

  always_comb begin
    rs_data    = data_v[0];
    rt_data    = data_v[1];
    rs_sel_ex  = sel_ex_v[0];
    rs_sel_mem = sel_mem_v[0];
    rt_sel_ex  = sel_ex_v[1];
    rt_sel_mem = sel_mem_v[1];
  end

endmodule

// File: rtl/decode_bypass_chk.sv
module decode_bypass_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic [ADDR_W-1:0] rs_addr,
  input logic [ADDR_W-1:0] rt_addr,
  input logic [ADDR_W-1:0] ex_dst,
  input logic              ex_wen,
  input logic [DATA_W-1:0] ex_result,
  input logic [ADDR_W-1:0] mem_dst,
  input logic              mem_wen,
  input logic [DATA_W-1:0] mem_result,
  input logic [DATA_W-1:0] rs_data,
  input logic [DATA_W-1:0] rt_data,
  input logic              rs_sel_ex,
  input logic              rs_sel_mem,
  input logic              rt_sel_ex,
  input logic              rt_sel_mem
);

  always_comb begin
    // R1: execute select only with a real, nonzero, written match
    assert_ex_match_R1: assert (!rs_sel_ex || (ex_wen && rs_addr == ex_dst && rs_addr != '0))
      else $error("rs execute select without a valid match");
    // R2: memory select never while execute writes the same register
    assert_mem_shadow_R2: assert (!rs_sel_mem || (mem_wen && rs_addr == mem_dst && !(ex_wen && ex_dst == rs_addr)))
      else $error("rs memory select while shadowed or unmatched");
    // R3: rt operand obeys the same rules
    assert_rt_rules_R3: assert ((!rt_sel_ex || (ex_wen && rt_addr == ex_dst && rt_addr != '0)) &&
                                (!rt_sel_mem || (mem_wen && rt_addr == mem_dst && !(ex_wen && ex_dst == rt_addr))))
      else $error("rt select violates match rules");
    // R4: execute path carries the ALU result
    assert_ex_data_R4: assert ((!rs_sel_ex || rs_data == ex_result) && (!rt_sel_ex || rt_data == ex_result))
      else $error("execute select without ALU result on data");
    // R5: memory path carries the memory-stage value
    assert_mem_data_R5: assert ((!rs_sel_mem || rs_data == mem_result) && (!rt_sel_mem || rt_data == mem_result))
      else $error("memory select without memory value on data");
    // R7: register zero reads as zero
    assert_zero_reg_R7: assert ((rs_addr != '0 || (rs_data == '0 && !rs_sel_ex && !rs_sel_mem)) &&
                                (rt_addr != '0 || (rt_data == '0 && !rt_sel_ex && !rt_sel_mem)))
      else $error("register zero produced nonzero data or a select");
    // R8: selects of one operand are exclusive
    assert_excl_sel_R8: assert ($onehot0({rs_sel_ex, rs_sel_mem}) && $onehot0({rt_sel_ex, rt_sel_mem}))
      else $error("both selects of one operand high");
  end

endmodule

bind decode_bypass decode_bypass_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .rs_addr    (rs_addr),
  .rt_addr    (rt_addr),
  .ex_dst     (ex_dst),
  .ex_wen     (ex_wen),
  .ex_result  (ex_result),
  .mem_dst    (mem_dst),
  .mem_wen    (mem_wen),
  .mem_result (mem_result),
  .rs_data    (rs_data),
  .rt_data    (rt_data),
  .rs_sel_ex  (rs_sel_ex),
  .rs_sel_mem (rs_sel_mem),
  .rt_sel_ex  (rt_sel_ex),
  .rt_sel_mem (rt_sel_mem)
);

// File: tb/sim_decode_bypass.sv
module sim_decode_bypass;

  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 5000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  rs_addr, rt_addr, ex_dst, mem_dst;
  logic [31:0] rs_rf_data, rt_rf_data, ex_result, mem_result;
  logic        ex_wen, mem_wen;
  logic [31:0] rs_data, rt_data;
  logic        rs_sel_ex, rs_sel_mem, rt_sel_ex, rt_sel_mem;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 0;

  decode_bypass u0 (
    .rs_addr(rs_addr), .rt_addr(rt_addr),
    .rs_rf_data(rs_rf_data), .rt_rf_data(rt_rf_data),
    .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_result(ex_result),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_result(mem_result),
    .rs_data(rs_data), .rt_data(rt_data),
    .rs_sel_ex(rs_sel_ex), .rs_sel_mem(rs_sel_mem),
    .rt_sel_ex(rt_sel_ex), .rt_sel_mem(rt_sel_mem)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  // Behavioural reference: walk stages youngest first, take the first writer.
  function automatic void ref_operand(input logic [4:0] a, input logic [31:0] rf,
                                      output logic [31:0] d, output logic sx, output logic sm);
    logic [4:0]  dst [2];
    logic        we  [2];
    logic [31:0] val [2];
    int          found;
    dst[0] = ex_dst;  we[0] = ex_wen;  val[0] = ex_result;
    dst[1] = mem_dst; we[1] = mem_wen; val[1] = mem_result;
    found = -1;
    if (a != 0) begin
      for (int s = 0; s < 2; s++) begin
        if (found < 0 && we[s] && dst[s] == a) found = s;
      end
    end
    sx = (found == 0);
    sm = (found == 1);
    if (a == 0)          d = 32'd0;
    else if (found >= 0) d = val[found];
    else                 d = rf;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    logic [31:0] d0, d1;
    logic x0, m0, x1, m1;
    ref_operand(rs_addr, rs_rf_data, d0, x0, m0);
    ref_operand(rt_addr, rt_rf_data, d1, x1, m1);
    chk(req, "rs_data",    rs_data,           d0);
    chk(req, "rt_data",    rt_data,           d1);
    chk(req, "rs_sel_ex",  {31'd0, rs_sel_ex},  {31'd0, x0});
    chk(req, "rs_sel_mem", {31'd0, rs_sel_mem}, {31'd0, m0});
    chk(req, "rt_sel_ex",  {31'd0, rt_sel_ex},  {31'd0, x1});
    chk(req, "rt_sel_mem", {31'd0, rt_sel_mem}, {31'd0, m1});
  endtask

  // Drive just after a rising edge, compare at the next falling edge (R9: zero latency).
  task automatic apply(input string req,
                       input logic [4:0] a_rs, input logic [4:0] a_rt,
                       input logic [4:0] xd, input logic xw,
                       input logic [4:0] md, input logic mw);
    @(posedge clk);
    #1;
    rs_addr = a_rs; rt_addr = a_rt;
    ex_dst = xd; ex_wen = xw; mem_dst = md; mem_wen = mw;
    rs_rf_data = 32'h1111_0000 | 32'(a_rs);
    rt_rf_data = 32'h2222_0000 | 32'(a_rt);
    ex_result  = 32'hEEEE_0000 | 32'(xd);
    mem_result = 32'hAAAA_0000 | 32'(md);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    rs_addr = '0; rt_addr = '0; ex_dst = '0; mem_dst = '0;
    ex_wen = 1'b0; mem_wen = 1'b0;
    rs_rf_data = '0; rt_rf_data = '0; ex_result = '0; mem_result = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: all-zero inputs give zero data and no selects (R7)
    compare_all("R7");
    rst_n = 1'b1;

    apply("R1", 5'd3, 5'd9, 5'd3, 1'b1, 5'd12, 1'b0);  // rs from execute
    apply("R1", 5'd3, 5'd9, 5'd3, 1'b0, 5'd12, 1'b0);  // no write enable: file data
    apply("R2", 5'd7, 5'd9, 5'd4, 1'b1, 5'd7, 1'b1);   // rs from memory
    apply("R2", 5'd7, 5'd9, 5'd7, 1'b1, 5'd7, 1'b1);   // execute shadows memory
    apply("R2", 5'd7, 5'd9, 5'd7, 1'b0, 5'd7, 1'b1);   // execute match not writing: memory used
    apply("R3", 5'd9, 5'd5, 5'd5, 1'b1, 5'd9, 1'b1);   // rt execute, rs memory
    apply("R3", 5'd6, 5'd6, 5'd1, 1'b1, 5'd6, 1'b1);   // both operands from memory
    apply("R4", 5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1);
    apply("R5", 5'd15, 5'd2, 5'd0, 1'b1, 5'd15, 1'b1);
    apply("R6", 5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1);
    apply("R7", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);   // zero destinations everywhere
    apply("R7", 5'd0, 5'd4, 5'd0, 1'b1, 5'd4, 1'b1);
    apply("R8", 5'd8, 5'd8, 5'd8, 1'b1, 5'd8, 1'b1);

    // Narrow address range so collisions are frequent (R8, R9)
    for (int i = 0; i < 400; i++) begin
      apply("R8", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    finish_run();
  end

  initial begin
    wait (cycles >= MAX_CYCLES);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer than %0d", cycles, MAX_CYCLES);
      finish_run();
    end
  end

endmodule